// File: doc/BRIEF.md
# Predicated Vector Element Step Iterator

This block keeps the loop position of a vector operation: an element counter and a sub-element counter. Each time the advance strobe is high on a clock edge, the block moves both counters to the next position of the loop. It raises a loop-end flag once the final position has been passed. Two nestings are offered. In the first, the sub-element counter is the inner loop. In the second, the element counter is the inner loop and the sub-element counter is the outer one.

When predicate skipping is enabled, elements whose predicate bit is clear are passed over. A single advance can therefore move the element counter by more than one. The whole scan completes within the cycle of the strobe. One instance serves the source side of a datapath and a second instance serves the destination side. Each instance is fed its own predicate mask and its own skip enable.

The vector length input must lie between 1 and 64. The sub-length input is the highest sub-element index, so a value of 0 means one sub-element per element. Both counters and the flag are registered. They take their new value on the clock edge at which the strobe is sampled.

Top module: `vec_step_iter`

## Requirements
- R1: While `rst_n` is low, or when `clr` is high at a clock edge, the next state is `step`=0, `substep`=0 and `loop_end`=0. `clr` takes priority over `adv` in the same cycle.
- R2: When `adv` and `clr` are both low at an edge, `step`, `substep` and `loop_end` keep their values.
- R3: In the sub-inner order (`pack`=0), an advance with `substep` different from `subvl` increments `substep` and leaves `step` unchanged.
- R4: In the sub-inner order, an advance with `substep` equal to `subvl` clears `substep` to 0 and moves `step` to the next eligible index.
- R5: In the sub-inner order, an advance with `substep` equal to `subvl` and no eligible index above `step` sets `step`=0, `substep`=0 and `loop_end`=1.
- R6: In the sub-outer order (`pack`=1), an advance moves `step` to the next eligible index and leaves `substep` unchanged, if such an index exists.
- R7: In the sub-outer order, an advance with no eligible index and `substep` different from `subvl` sets `step`=0, whatever mask bit 0 is, and increments `substep`.
- R8: In the sub-outer order, an advance with no eligible index and `substep` equal to `subvl` sets `loop_end`=1, sets `step`=`vl`-1 and leaves `substep` unchanged.
- R9: With `skip_en`=1, the next eligible index is the lowest index i above `step` and below `vl` whose mask bit `mask[i]` is 1. It is reached in one advance.
- R10: With `skip_en`=0, the mask is ignored and the next eligible index is `step`+1 if that is below `vl`.
- R11: `loop_end` stays at 1 until a clear or a reset. Further advances still move the counters by the rules above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of both counters and the loop-end flag |
| adv | input | 1 | Advance strobe; one loop position per cycle in which it is high |
| vl | input | 7 | Vector length, 1 to 64 |
| subvl | input | 2 | Highest sub-element index (0 to 3) |
| pack | input | 1 | Loop order: 0 = sub-element inner, 1 = sub-element outer |
| skip_en | input | 1 | 1 = pass over elements whose mask bit is clear |
| mask | input | 64 | Predicate mask; bit i belongs to element i |
| step | output | 7 | Current element index |
| substep | output | 2 | Current sub-element index |
| loop_end | output | 1 | Sticky flag: the final loop position has been passed |

## Verification
The clear and the advance strobe can arrive in the same cycle, so the clear priority has to be tested. The bench first drives the block into a state in which every output is nonzero, using the sub-outer order with skipping and `loop_end` already set. It then raises `clr` and `adv` together for one edge. The check passes only if all three outputs read zero on the next sample. The result of the advance alone would have been different, so the check shows which input won.

// File: rtl/stepit_pkg.sv
// Package: stepit_pkg
// Shared default sizes and the classification of an advance for the vector
// element step iterator. Assumes a mask of at most 2**STEP_W - 1 bits.
package stepit_pkg;
    localparam int MASK_W = 64;   // predicate mask width, also maximum vector length
    localparam int STEP_W = 7;    // element counter width (holds 0..MASK_W)
    localparam int SUB_W  = 2;    // sub-element counter width

    // What an advance did to the loop position.
    typedef enum logic [1:0] {
        ADV_SUB  = 2'd0,   // only the sub-element counter moved
        ADV_STEP = 2'd1,   // element counter moved to an eligible index
        ADV_WRAP = 2'd2,   // inner loop wrapped, outer counter moved
        ADV_END  = 2'd3    // last loop position passed
    } adv_kind_e;
endpackage

// File: rtl/stepit_window.sv
// Module: stepit_window
// Marks every element index that the next advance may land on. An index is
// eligible when it lies strictly above the current step, strictly below the
// vector length, and either skipping is off or its mask bit is set.
// Assumes MASK_W < 2**STEP_W so every bit position fits in a step value.
module stepit_window #(
    parameter int MASK_W = 64,
    parameter int STEP_W = 7
) (
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] vl,
    input  logic [MASK_W-1:0] mask,
    input  logic              skip_en,
    output logic [MASK_W-1:0] elig
);
    // One comparator pair per mask bit, built by generate.
    for (genvar i = 0; i < MASK_W; i++) begin : g_pos
        localparam logic [STEP_W-1:0] POS = STEP_W'(i);
        // Eligibility of index i.
        assign elig[i] = (POS > step) && (POS < vl) && (mask[i] || !skip_en);
    end
endmodule

// File: rtl/stepit_lowest.sv
// Module: stepit_lowest
// Finds the lowest set bit of a vector and reports its position.
// Assumes W < 2**IDX_W. Returns found=0 and idx=0 for an all-zero input.
module stepit_lowest #(
    parameter int W     = 64,
    parameter int IDX_W = 7
) (
    input  logic [W-1:0]     bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit writes last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/stepit_next.sv
// Module: stepit_next
// Computes the loop position that follows the current one, for either loop
// order. Purely combinational. Assumes the eligible-index search result
// (found, idx) was computed from the same step, vl and mask.
module stepit_next
    import stepit_pkg::*;
#(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2
) (
    input  logic [STEP_W-1:0] step,
    input  logic [SUB_W-1:0]  substep,
    input  logic [STEP_W-1:0] vl,
    input  logic [SUB_W-1:0]  subvl,
    input  logic              pack,
    input  logic              found,
    input  logic [STEP_W-1:0] idx,
    output logic [STEP_W-1:0] nxt_step,
    output logic [SUB_W-1:0]  nxt_sub,
    output logic              set_end,
    output adv_kind_e         kind
);
    logic              sub_last;
    logic [STEP_W-1:0] last_pos;

    // Loop limits for the current configuration.
    assign sub_last = (substep == subvl);
    assign last_pos = vl - 1'b1;

    // Select the outcome of the advance by loop order.
    always_comb begin
        nxt_step = step;
        nxt_sub  = substep;
        kind     = ADV_SUB;
        if (!pack) begin
            // Sub-element counter is the inner loop.
            if (!sub_last) begin
                nxt_sub = substep + 1'b1;
                kind    = ADV_SUB;
            end else if (found) begin
                nxt_sub  = '0;
                nxt_step = idx;
                kind     = ADV_STEP;
            end else begin
                nxt_sub  = '0;
                nxt_step = '0;
                kind     = ADV_END;
            end
        end else begin
            // Element counter is the inner loop.
            if (found) begin
                nxt_step = idx;
                kind     = ADV_STEP;
            end else if (!sub_last) begin
                nxt_step = '0;
                nxt_sub  = substep + 1'b1;
                kind     = ADV_WRAP;
            end else begin
                nxt_step = last_pos;
                kind     = ADV_END;
            end
        end
    end

    // Loop end is raised only by the final advance.
    assign set_end = (kind == ADV_END);
endmodule

// File: rtl/stepit_regs.sv
// Module: stepit_regs
// Holds the element counter, sub-element counter and the sticky loop-end
// flag. Synchronous active-low reset; synchronous clear overrides advance.
module stepit_regs #(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [STEP_W-1:0] nxt_step,
    input  logic [SUB_W-1:0]  nxt_sub,
    input  logic              set_end,
    output logic [STEP_W-1:0] step,
    output logic [SUB_W-1:0]  substep,
    output logic              loop_end
);
    // State update: reset/clear first, then advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            step     <= '0;
            substep  <= '0;
            loop_end <= 1'b0;
        end else if (adv) begin
            step     <= nxt_step;
            substep  <= nxt_sub;
            loop_end <= loop_end | set_end;
        end
    end
endmodule

// File: rtl/vec_step_iter.sv
// Module: vec_step_iter (top)
// Predicated vector element step iterator. One advance strobe moves the
// loop position by one, passing over masked elements in the same cycle when
// skipping is enabled. Assumes 1 <= vl <= MASK_W and MASK_W < 2**STEP_W.
module vec_step_iter
    import stepit_pkg::*;
#(
    parameter int MASK_W = stepit_pkg::MASK_W,
    parameter int STEP_W = stepit_pkg::STEP_W,
    parameter int SUB_W  = stepit_pkg::SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [STEP_W-1:0] vl,
    input  logic [SUB_W-1:0]  subvl,
    input  logic              pack,
    input  logic              skip_en,
    input  logic [MASK_W-1:0] mask,
    output logic [STEP_W-1:0] step,
    output logic [SUB_W-1:0]  substep,
    output logic              loop_end
);
    logic [MASK_W-1:0] elig;
    logic              found;
    logic [STEP_W-1:0] idx;
    logic [STEP_W-1:0] nxt_step;
    logic [SUB_W-1:0]  nxt_sub;
    logic              set_end;
    adv_kind_e         kind;

    stepit_window #(.MASK_W(MASK_W), .STEP_W(STEP_W)) u_window (
        .step    (step),
        .vl      (vl),
        .mask    (mask),
        .skip_en (skip_en),
        .elig    (elig)
    );

    stepit_lowest #(.W(MASK_W), .IDX_W(STEP_W)) u_lowest (
        .bits  (elig),
        .found (found),
        .idx   (idx)
    );

    stepit_next #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_next (
        .step     (step),
        .substep  (substep),
        .vl       (vl),
        .subvl    (subvl),
        .pack     (pack),
        .found    (found),
        .idx      (idx),
        .nxt_step (nxt_step),
        .nxt_sub  (nxt_sub),
        .set_end  (set_end),
        .kind     (kind)
    );

    stepit_regs #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (adv),
        .nxt_step (nxt_step),
        .nxt_sub  (nxt_sub),
        .set_end  (set_end),
        .step     (step),
        .substep  (substep),
        .loop_end (loop_end)
    );
endmodule

// File: rtl/vec_step_iter_chk.sv
// Module: vec_step_iter_chk
// Assertion checker for vec_step_iter, attached with bind below.
module vec_step_iter_chk #(
    parameter int MASK_W = 64,
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              adv,
    input logic [STEP_W-1:0] vl,
    input logic [SUB_W-1:0]  subvl,
    input logic              pack,
    input logic              skip_en,
    input logic [MASK_W-1:0] mask,
    input logic [STEP_W-1:0] step,
    input logic [SUB_W-1:0]  substep,
    input logic              loop_end
);
    localparam int MIDX_W = $clog2(MASK_W);

    logic [MASK_W-1:0] mask_q;

    // Mask seen at the previous edge, for checking where a skip landed.
    always_ff @(posedge clk) mask_q <= mask;

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (step == '0) && (substep == '0) && !loop_end);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(step) && $stable(substep) && $stable(loop_end));

    p_sub_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !pack && (substep != subvl))
        |=> (substep == SUB_W'($past(substep) + 1'b1)) && $stable(step));

    p_skip_land_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && skip_en && !pack && (substep == subvl))
        |=> loop_end || mask_q[step[MIDX_W-1:0]]);

    p_plain_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !skip_en && pack && (STEP_W'(step + 1'b1) < vl))
        |=> (step == STEP_W'($past(step) + 1'b1)) && $stable(substep));

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_end && !clr) |=> loop_end);
endmodule

bind vec_step_iter vec_step_iter_chk #(
    .MASK_W(MASK_W), .STEP_W(STEP_W), .SUB_W(SUB_W)
) u_chk (.*);

// File: tb/tb_vec_step_iter.sv
`timescale 1ns/1ps
module tb_vec_step_iter;
    logic        clk = 1'b0;
    logic        rst_n, clr, adv, pack, skip_en;
    logic [6:0]  vl;
    logic [1:0]  subvl;
    logic [63:0] mask;
    logic [6:0]  step;
    logic [1:0]  substep;
    logic        loop_end;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vec_step_iter dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .vl(vl), .subvl(subvl),
        .pack(pack), .skip_en(skip_en), .mask(mask),
        .step(step), .substep(substep), .loop_end(loop_end)
    );

    task automatic chk(input logic [6:0] es, input logic [1:0] eu, input logic el,
                       input string tag);
        checks++;
        if (step !== es || substep !== eu || loop_end !== el) begin
            errors++;
            $display("FAIL %s: got step=%0d sub=%0d end=%0d, expected step=%0d sub=%0d end=%0d",
                     tag, step, substep, loop_end, es, eu, el);
        end
    endtask

    task automatic pulse_adv();
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic setup(input logic [6:0] v, input logic [1:0] sv, input logic pk,
                         input logic sk, input logic [63:0] m);
        vl = v; subvl = sv; pack = pk; skip_en = sk; mask = m;
        do_clear();
    endtask

    // Sub-inner order, no skipping: counting, wrap, stickiness, hold, clear.
    task automatic test_normal_plain();
        setup(7'd3, 2'd1, 1'b0, 1'b0, 64'h0);
        chk(0, 0, 0, "R1 clear");
        pulse_adv(); chk(0, 1, 0, "R3 sub inc");
        pulse_adv(); chk(1, 0, 0, "R4 step move");
        pulse_adv(); chk(1, 1, 0, "R3 sub inc");
        pulse_adv(); chk(2, 0, 0, "R4 step move");
        pulse_adv(); chk(2, 1, 0, "R3 sub inc");
        pulse_adv(); chk(0, 0, 1, "R5 loop end");
        pulse_adv(); chk(0, 1, 1, "R11 sticky");
        repeat (3) @(negedge clk);
        chk(0, 1, 1, "R2 hold");
        do_clear(); chk(0, 0, 0, "R1 clear");
    endtask

    // Sub-inner order with skipping: mask bits 2 and 5, vl=8.
    task automatic test_normal_skip();
        setup(7'd8, 2'd0, 1'b0, 1'b1, 64'h24);
        pulse_adv(); chk(2, 0, 0, "R9 skip to 2");
        pulse_adv(); chk(5, 0, 0, "R9 skip to 5");
        pulse_adv(); chk(0, 0, 1, "R5 none left");
    endtask

    // Skipping off: a zero mask is ignored.
    task automatic test_no_skip();
        setup(7'd4, 2'd0, 1'b0, 1'b0, 64'h0);
        pulse_adv(); chk(1, 0, 0, "R10 plus one");
        pulse_adv(); chk(2, 0, 0, "R10 plus one");
        pulse_adv(); chk(3, 0, 0, "R10 plus one");
        pulse_adv(); chk(0, 0, 1, "R5 wrap");
    endtask

    // Sub-outer order, no skipping.
    task automatic test_pack_plain();
        setup(7'd3, 2'd1, 1'b1, 1'b0, 64'h0);
        pulse_adv(); chk(1, 0, 0, "R6 step");
        pulse_adv(); chk(2, 0, 0, "R6 step");
        pulse_adv(); chk(0, 1, 0, "R7 wrap");
        pulse_adv(); chk(1, 1, 0, "R6 step");
        pulse_adv(); chk(2, 1, 0, "R6 step");
        pulse_adv(); chk(2, 1, 1, "R8 end");
    endtask

    // Sub-outer order with skipping: only mask bit 3 set, vl=6.
    task automatic test_pack_skip();
        setup(7'd6, 2'd1, 1'b1, 1'b1, 64'h8);
        pulse_adv(); chk(3, 0, 0, "R9 skip to 3");
        pulse_adv(); chk(0, 1, 0, "R7 wrap masked 0");
        pulse_adv(); chk(3, 1, 0, "R6 skip to 3");
        pulse_adv(); chk(5, 1, 1, "R8 end at vl-1");
    endtask

    // Clear and advance in the same cycle, from a nonzero state.
    task automatic test_clr_wins();
        adv = 1'b1; clr = 1'b1;
        @(negedge clk);
        adv = 1'b0; clr = 1'b0;
        chk(0, 0, 0, "R1 clear beats advance");
    endtask

    // Full-width mask: jump from 0 to 63 in one advance.
    task automatic test_wide();
        setup(7'd64, 2'd0, 1'b0, 1'b1, 64'h8000_0000_0000_0000);
        pulse_adv(); chk(63, 0, 0, "R9 jump to 63");
        pulse_adv(); chk(0, 0, 1, "R5 wrap at 64");
    endtask

    // Vector length of one.
    task automatic test_vl_one();
        setup(7'd1, 2'd1, 1'b0, 1'b0, 64'h0);
        pulse_adv(); chk(0, 1, 0, "R3 vl1 sub");
        pulse_adv(); chk(0, 0, 1, "R5 vl1 end");
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b0; adv = 1'b1; pack = 1'b0; skip_en = 1'b0;
        vl = 7'd4; subvl = 2'd0; mask = '1;
        repeat (3) @(negedge clk);
        chk(0, 0, 0, "R1 reset");
        adv = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        test_normal_plain();
        test_normal_skip();
        test_no_skip();
        test_pack_plain();
        test_pack_skip();
        test_clr_wins();
        test_wide();
        test_vl_one();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule